// File: doc/BRIEF.md
# Three-Wire Configuration Register Bank

This block is the write-only control slave of a radio transceiver. A host moves 16-bit words in over three wires: an active-low frame enable, a serial clock and a data line. Each word holds a 2-bit register selector in its two lowest bits and a 14-bit payload above them. When the frame closes with exactly sixteen bits received, the payload lands in one of three control registers. The register fields drive the transceiver's configuration outputs directly.

The first register (selector 0) carries the RSSI clip disable (word bit 9), the analog-pin function select (word bit 8) and the transmit power control bit (word bit 7). The second register (selector 1) carries the 12-bit PLL divide ratio in word bits 13:2. The third register (selector 2) carries a 3-bit analog test-mode code in word bits 4:2 and a 3-bit digital test-mode code in word bits 7:5. Its upper bits are reserved. The power control bit does not go straight to its pin. It is held and copied across only when the receive-enable input falls. It then reaches the pin only while the analog-pin select is 0. Nothing can be read back.

All serial inputs and the receive-enable input are sampled by the system clock `clk`, which must run several times faster than the serial clock. Reset is synchronous and active low.

Top module: `cfgw_bank`

## Requirements
- R1: While `rst_n` is low, all three registers and the held power-control value clear to 0, so every output reads 0 one clock later.
- R2: Bits arrive most significant first. Word bits 1:0 select the register. Word bits 15:2 are written to it in the clock cycle in which `serEn` is first seen high after a frame.
- R3: A data bit is taken only at a rising edge of `serClk` while `serEn` is low. The level of `serData` at that rising edge counts; later changes while `serClk` stays high do not.
- R4: A frame that closes after any count of rising edges other than 16 (for example 15 or 17) leaves all registers unchanged.
- R5: A word whose selector is 3 leaves all registers unchanged.
- R6: `pllDiv` equals word bits 13:2 of the last word written to register 1.
- R7: `rssiClipOff` equals word bit 9 and `aoutSel` equals word bit 8 of register 0. Word bit 7 of register 0 is copied to the held power-control value only in the clock cycle in which `rxOn` is first seen low after being high.
- R8: `tpcLevel` equals the held power-control value while `aoutSel` is 0, and is 0 while `aoutSel` is 1.
- R9: `atmSel` equals word bits 4:2 and `dtmSel` equals word bits 7:5 of register 2. `testPort` is 1 exactly when `atmSel` is nonzero.
- R10: A register keeps its value until a valid word addresses it. Writing one register does not disturb the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serEn | input | 1 | Frame enable, low while a word is shifted |
| serClk | input | 1 | Serial bit clock |
| serData | input | 1 | Serial data, MSB first |
| rxOn | input | 1 | Receive enable; its falling edge releases the power-control bit |
| pllDiv | output | 12 | PLL divide ratio |
| tpcLevel | output | 1 | Transmit power control pin level |
| aoutSel | output | 1 | Analog pin function select |
| rssiClipOff | output | 1 | 1 disables RSSI clipping |
| atmSel | output | 3 | Analog test-mode code |
| dtmSel | output | 3 | Digital test-mode code |
| testPort | output | 1 | Analog pins serve as test ports |

## Verification
Each input is taken at the first rising `clk` edge that sees its new level. A committed word therefore appears on the outputs right after the edge that first sees `serEn` high. A new power-control level appears right after the edge that first sees `rxOn` low. The bench drives inputs on falling `clk` edges and compares every output against its behavioural model on every falling edge. Each scripted check is made two falling edges after the stimulus that closes the action, when the result is already settled.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  // strobes from the control side to the datapath
  typedef struct packed {
    logic shift;    // take serData into the shifter
    logic commit;   // store the shifted word
    logic tpcLoad;  // copy power-control bit to its holder
  } cfgw_strobe_t;
endpackage

// File: rtl/cfgw_ctrl.sv
module cfgw_ctrl
  import cfgw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         serEn,
  input  logic         serClk,
  input  logic         rxOn,
  output cfgw_strobe_t st
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             serEnQ, serClkQ, rxOnQ;
  logic [CNT_W-1:0] bitCnt;
  logic             clkRise, enRise, enFall, rxFall;

  always_comb begin
    clkRise = serClk & ~serClkQ;
    enRise  = serEn & ~serEnQ;
    enFall  = ~serEn & serEnQ;
    rxFall  = ~rxOn & rxOnQ;
    st.shift   = clkRise & ~serEn;
    st.commit  = enRise & (bitCnt == CNT_W'(WORD_W));
    st.tpcLoad = rxFall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serEnQ  <= 1'b1;
      serClkQ <= 1'b0;
      rxOnQ   <= 1'b0;
      bitCnt  <= '0;
    end else begin
      serEnQ  <= serEn;
      serClkQ <= serClk;
      rxOnQ   <= rxOn;
      if (enRise || enFall)
        bitCnt <= '0;
      else if (st.shift && bitCnt != CNT_W'(CNT_MAX))
        bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfgw_dpath.sv
module cfgw_dpath
  import cfgw_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int NUM_REGS = 3,
  parameter int PLL_W    = 12,
  parameter int PLL_LSB  = 2,
  parameter int TPC_BIT  = 7,
  parameter int AOUT_BIT = 8,
  parameter int CLIP_BIT = 9,
  parameter int TM_W     = 3,
  parameter int ATM_LSB  = 2,
  parameter int DTM_LSB  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serData,
  input  cfgw_strobe_t     st,
  output logic [PLL_W-1:0] pllDiv,
  output logic             tpcLevel,
  output logic             aoutSel,
  output logic             rssiClipOff,
  output logic [TM_W-1:0]  atmSel,
  output logic [TM_W-1:0]  dtmSel,
  output logic             testPort
);
  localparam int DATA_W   = WORD_W - ADDR_W;
  localparam int CFG_REG  = 0;
  localparam int CHAN_REG = 1;
  localparam int TEST_REG = 2;

  logic [WORD_W-1:0] shiftReg;
  logic [DATA_W-1:0] cfgRegs [NUM_REGS];
  logic [ADDR_W-1:0] wordAddr;
  logic              tpcHeld;

  assign wordAddr = shiftReg[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      shiftReg <= '0;
    else if (st.shift)
      shiftReg <= {shiftReg[WORD_W-2:0], serData};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfgRegs[g] <= '0;
      else if (st.commit && wordAddr == ADDR_W'(g))
        cfgRegs[g] <= shiftReg[WORD_W-1:ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tpcHeld <= 1'b0;
    else if (st.tpcLoad)
      tpcHeld <= cfgRegs[CFG_REG][TPC_BIT-ADDR_W];
  end

  always_comb begin
    pllDiv      = cfgRegs[CHAN_REG][PLL_LSB-ADDR_W +: PLL_W];
    aoutSel     = cfgRegs[CFG_REG][AOUT_BIT-ADDR_W];
    rssiClipOff = cfgRegs[CFG_REG][CLIP_BIT-ADDR_W];
    atmSel      = cfgRegs[TEST_REG][ATM_LSB-ADDR_W +: TM_W];
    dtmSel      = cfgRegs[TEST_REG][DTM_LSB-ADDR_W +: TM_W];
    testPort    = |atmSel;
    tpcLevel    = tpcHeld & ~aoutSel;
  end
endmodule

// File: rtl/cfgw_bank.sv
module cfgw_bank
  import cfgw_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int NUM_REGS = 3,
  parameter int PLL_W    = 12,
  parameter int TM_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serEn,
  input  logic             serClk,
  input  logic             serData,
  input  logic             rxOn,
  output logic [PLL_W-1:0] pllDiv,
  output logic             tpcLevel,
  output logic             aoutSel,
  output logic             rssiClipOff,
  output logic [TM_W-1:0]  atmSel,
  output logic [TM_W-1:0]  dtmSel,
  output logic             testPort
);
  cfgw_strobe_t st;

  cfgw_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .serEn(serEn), .serClk(serClk),
    .rxOn(rxOn), .st(st)
  );

  cfgw_dpath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .PLL_W(PLL_W), .TM_W(TM_W)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .serData(serData), .st(st),
    .pllDiv(pllDiv), .tpcLevel(tpcLevel), .aoutSel(aoutSel),
    .rssiClipOff(rssiClipOff), .atmSel(atmSel), .dtmSel(dtmSel),
    .testPort(testPort)
  );
endmodule

// File: rtl/cfgw_bank_chk.sv
module cfgw_bank_chk #(
  parameter int PLL_W = 12,
  parameter int TM_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             serEn,
  input logic             rxOn,
  input logic [PLL_W-1:0] pllDiv,
  input logic             tpcLevel,
  input logic             aoutSel,
  input logic             rssiClipOff,
  input logic [TM_W-1:0]  atmSel,
  input logic [TM_W-1:0]  dtmSel,
  input logic             testPort
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pllDiv == '0 && !tpcLevel && !aoutSel && !rssiClipOff &&
                atmSel == '0 && dtmSel == '0 && !testPort));

  // R2
  pll_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pllDiv != $past(pllDiv)) |-> ($past(serEn) && !$past(serEn, 2)));

  // R10
  test_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (atmSel != $past(atmSel) || dtmSel != $past(dtmSel) ||
     aoutSel != $past(aoutSel) || rssiClipOff != $past(rssiClipOff))
    |-> ($past(serEn) && !$past(serEn, 2)));

  // R7
  tpc_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tpcLevel) |-> (($past(rxOn, 2) && !$past(rxOn)) || $fell(aoutSel)));

  // R8
  tpc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aoutSel |-> !tpcLevel);

  // R9
  test_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    testPort == (atmSel != '0));
endmodule

bind cfgw_bank cfgw_bank_chk #(.PLL_W(PLL_W), .TM_W(TM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .serEn(serEn), .rxOn(rxOn), .pllDiv(pllDiv),
  .tpcLevel(tpcLevel), .aoutSel(aoutSel), .rssiClipOff(rssiClipOff),
  .atmSel(atmSel), .dtmSel(dtmSel), .testPort(testPort)
);

// File: tb/cfgw_bank_tb_top.sv
`timescale 1ns/1ps
module cfgw_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serEn = 1'b1, serClk = 1'b0, serData = 1'b0, rxOn = 1'b0;
  logic [11:0] pllDiv;
  logic tpcLevel, aoutSel, rssiClipOff, testPort;
  logic [2:0] atmSel, dtmSel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cfgw_bank dut_i (
    .clk(clk), .rst_n(rst_n), .serEn(serEn), .serClk(serClk),
    .serData(serData), .rxOn(rxOn), .pllDiv(pllDiv), .tpcLevel(tpcLevel),
    .aoutSel(aoutSel), .rssiClipOff(rssiClipOff), .atmSel(atmSel),
    .dtmSel(dtmSel), .testPort(testPort)
  );

  // behavioural reference: bit queue plus three stored words
  bit          mBits[$];
  logic [15:0] mWord [3];
  logic        mTpc, mEnPrev, mClkPrev, mRxPrev;

  always @(posedge clk) begin
    if (!rst_n) begin
      mBits.delete();
      for (int i = 0; i < 3; i++) mWord[i] = '0;
      mTpc = 0; mEnPrev = 1; mClkPrev = 0; mRxPrev = 0;
    end else begin
      logic [15:0] w;
      if (!rxOn && mRxPrev) mTpc = mWord[0][7];
      if (!serEn && mEnPrev) mBits.delete();
      if (serClk && !mClkPrev && !serEn) mBits.push_back(serData);
      if (serEn && !mEnPrev) begin
        if (mBits.size() == 16) begin
          w = '0;
          foreach (mBits[i]) w[15-i] = mBits[i];
          if (w[1:0] != 2'd3) mWord[w[1:0]] = w;
        end
        mBits.delete();
      end
      mEnPrev = serEn; mClkPrev = serClk; mRxPrev = rxOn;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && cycles > 8) begin
      check("R10", "model pllDiv", {4'h0, pllDiv}, {4'h0, mWord[1][13:2]});
      check("R7", "model aout/clip", {14'h0, aoutSel, rssiClipOff},
            {14'h0, mWord[0][8], mWord[0][9]});
      check("R8", "model tpcLevel", {15'h0, tpcLevel},
            {15'h0, mTpc & ~mWord[0][8]});
      check("R9", "model test modes", {9'h0, testPort, dtmSel, atmSel},
            {9'h0, mWord[2][4:2] != 3'd0, mWord[2][7:5], mWord[2][4:2]});
    end
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic sendBits(input logic [31:0] w, input int n, input bit glitch);
    @(negedge clk) serEn = 0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) begin serData = w[i]; serClk = 0; end
      @(negedge clk) serClk = 1;
      if (glitch) @(negedge clk) serData = ~w[i];
      @(negedge clk) serClk = 0;
    end
    @(negedge clk) serEn = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rxFallPulse();
    @(negedge clk) rxOn = 1;
    @(negedge clk);
    @(negedge clk) rxOn = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1", "reset outputs",
          {pllDiv, tpcLevel, aoutSel, rssiClipOff, testPort}, 16'h0);
    check("R1", "reset modes", {10'h0, dtmSel, atmSel}, 16'h0);

    // R3: clock pulses with enable high are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) serClk = 1;
      @(negedge clk) serClk = 0;
    end
    // R2 R6: divide ratio A5C to register 1
    sendBits(32'h2971, 16, 0);
    check("R6", "pllDiv written", {4'h0, pllDiv}, 16'h0A5C);

    // R7: register 0 clip=1 tpc=1 aout=0; pin waits for rxOn fall
    sendBits(32'h0280, 16, 0);
    check("R7", "rssiClipOff", {15'h0, rssiClipOff}, 16'h1);
    check("R7", "tpc before rxOn fall", {15'h0, tpcLevel}, 16'h0);
    rxFallPulse();
    check("R7", "tpc after rxOn fall", {15'h0, tpcLevel}, 16'h1);

    // R8: aout select masks tpc, then unmasking shows held value
    sendBits(32'h0100, 16, 0);
    check("R8", "tpc masked", {14'h0, aoutSel, tpcLevel}, 16'h2);
    sendBits(32'h0000, 16, 0);
    check("R8", "tpc held unmasked", {15'h0, tpcLevel}, 16'h1);
    rxFallPulse();
    check("R7", "tpc cleared on fall", {15'h0, tpcLevel}, 16'h0);

    // R9: test register atm=5 dtm=3, then atm=0 dtm=7
    sendBits(32'h0076, 16, 0);
    check("R9", "atm/dtm/flag", {9'h0, testPort, dtmSel, atmSel}, 16'h5D);
    sendBits(32'h00E2, 16, 0);
    check("R9", "flag low", {9'h0, testPort, dtmSel, atmSel}, 16'h38);
    // R10: other registers undisturbed
    check("R10", "pllDiv kept", {4'h0, pllDiv}, 16'h0A5C);

    // R4: short and long frames discarded
    sendBits(32'h3FF9 >> 1, 15, 0);
    check("R4", "15-bit frame", {4'h0, pllDiv}, 16'h0A5C);
    sendBits({15'h0, 16'h3FF9, 1'b1}, 17, 0);
    check("R4", "17-bit frame", {4'h0, pllDiv}, 16'h0A5C);

    // R5: selector 3 discarded
    sendBits(32'hFFFF, 16, 0);
    check("R5", "addr3 pll", {4'h0, pllDiv}, 16'h0A5C);
    check("R5", "addr3 modes", {9'h0, testPort, dtmSel, atmSel}, 16'h38);

    // R3: data flipped while serClk high must not count
    sendBits(32'h1235, 16, 1);
    check("R3", "sample at rise", {4'h0, pllDiv}, 16'h048D);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule